// File: doc/BRIEF.md
# Event-Counting Reload Timer

This block is a 16-bit down-counter that advances on transitions of an external event input, not on a divided system clock. Software programs a 16-bit start value and the control fields through a byte-wide register port. Writing the start command with counting enabled copies the start value into the counter. Each qualifying edge on the event input then takes one off the count. The event input first passes through a two-flop synchronizer. The edge to count can be rising only, falling only, or both, and at most one edge is counted per system clock.

A qualifying edge that arrives while the count is 0x0000 is an underflow: the count wraps to 0xFFFF. An underflow sets a sticky status flag, and the interrupt line is asserted while that flag and the interrupt-enable bit are both set. In auto-reload mode the counter is reloaded on underflow and counting goes on. In single-run mode the counter stops at 0xFFFF until the next start command. The output pin toggles on every underflow in auto-reload mode. In single-run mode it acts as a gate that is active while counting. While the output is disabled, the pin sits at the programmed idle level.

Top module: `event_reload_timer`

## Requirements
- R1: After reset every readable register and the counter read as 0x00, and both irqOut and pinOut are 0.
- R2: A write to address 0 with bit 1 (enable) and bit 0 (start) both 1 loads the start value (low byte at address 2, high byte at address 3) into the counter, readable at addresses 4 (low) and 5 (high). Bit 0 of address 0 always reads back as 0.
- R3: The edge field is bits 1:0 of address 1. Code 01 counts rising edges, 10 falling edges, 11 both, and 00 counts nothing.
- R4: Edges are counted only while the source field, bits 5:3 of address 1, equals 3'b111. With any other code the count holds.
- R5: While the counter is running, each qualifying edge decrements the count by exactly one.
- R6: An edge at count 0x0000 sets the underflow flag (address 0 bit 2). Writing 0 to that bit clears the flag, and writing 1 leaves it unchanged.
- R7: irqOut is 1 exactly when the underflow flag and interrupt-enable (address 0 bit 3) are both 1.
- R8: With reload select (address 0 bit 4) at 1, an underflow reloads the start value and counting continues.
- R9: With reload select at 0, an underflow leaves the count at 0xFFFF and later edges are ignored until the next start command.
- R10: With output enable (address 0 bit 6) at 0, pinOut equals the idle-level bit (address 0 bit 5).
- R11: With output enable and reload select both 1, a start command sets pinOut to the idle level, and pinOut inverts on each underflow.
- R12: With output enable 1 and reload select 0, pinOut is the inverse of the idle level from the start command until the underflow, and returns to the idle level after it.
- R13: Writing 0 to the enable bit stops counting, and later edges leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address (combinational read) |
| rdData | output | 8 | Read data |
| evtIn | input | 1 | External event input (asynchronous) |
| irqOut | output | 1 | Interrupt request |
| pinOut | output | 1 | Toggle or gate output pin |

## Verification
The counting path is driven with the same pulse trains under each edge code, and each code is expected to give a different final count. Rising-only and falling-only give one decrement per pulse, both-edges gives two, and code 00 gives none, so a swapped or merged decode shows up as a wrong count. Pulse counts are chosen to land just before, on and just past zero. This separates a plain decrement from the underflow path, and the auto-reload value from the single-run 0xFFFF stop. The pin, flag and interrupt are checked at the same points, in both modes and with the interrupt enable both on and off.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;
  localparam logic [2:0] EXT_SRC = 3'b111;

  localparam logic [ADDR_W-1:0] A_CTRL_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_RLD_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd5;

  typedef struct packed {
    logic loadStart;
    logic decrement;
    logic pinSet;
    logic pinSetVal;
    logic pinToggle;
  } ctrl_strobe_t;
endpackage

// File: rtl/evt_timer_datapath.sv
module evt_timer_datapath
  import evt_timer_pkg::*;
#(
  parameter int WIDTH = CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobe,
  input  logic [WIDTH-1:0] reloadVal,
  output logic [WIDTH-1:0] countVal,
  output logic             countZero,
  output logic             pinReg
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
      pinReg   <= 1'b0;
    end else begin
      if (strobe.loadStart)      countVal <= reloadVal;
      else if (strobe.decrement) countVal <= countVal - 1'b1;
      if (strobe.pinSet)         pinReg <= strobe.pinSetVal;
      else if (strobe.pinToggle) pinReg <= ~pinReg;
    end
  end

  assign countZero = (countVal == '0);

  // R2 / R8: a load strobe leaves the start value in the counter
  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadStart |=> countVal == $past(reloadVal));
  // R5: one step per counted edge
  assert_step_one_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decrement && !strobe.loadStart) |=> countVal == $past(countVal) - 1'b1);
  // R11: toggle strobe inverts the pin
  assert_pin_toggle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pinToggle && !strobe.pinSet) |=> pinReg != $past(pinReg));
endmodule

// File: rtl/evt_timer_control.sv
module evt_timer_control
  import evt_timer_pkg::*;
#(
  parameter int WIDTH = CNT_W,
  parameter logic [2:0] SRC_CODE = EXT_SRC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              evtIn,
  input  logic              countZero,
  output ctrl_strobe_t      strobe,
  output logic [WIDTH-1:0]  reloadVal,
  output logic [7:0]        ctrlLoRd,
  output logic [7:0]        ctrlHiRd,
  output logic              irqOut,
  output logic              outEnable,
  output logic              idleLevel
);
  logic       reloadSel, intEnable, uFlag, cntEnable, running;
  logic [2:0] srcSel;
  logic [1:0] edgeSel;
  logic [2:0] syncPipe;
  logic       riseSeen, fallSeen, edgeHit, underflow, startCmd, wrLo;

  assign wrLo     = wrEn && (wrAddr == A_CTRL_LO);
  assign startCmd = wrLo && wrData[1] && wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[1:0], evtIn};
  end

  assign riseSeen  = syncPipe[1] && !syncPipe[2];
  assign fallSeen  = !syncPipe[1] && syncPipe[2];
  assign edgeHit   = running && (srcSel == SRC_CODE) &&
                     ((edgeSel[0] && riseSeen) || (edgeSel[1] && fallSeen));
  assign underflow = edgeHit && countZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outEnable <= 1'b0; idleLevel <= 1'b0; reloadSel <= 1'b0;
      intEnable <= 1'b0; uFlag     <= 1'b0; cntEnable <= 1'b0;
      running   <= 1'b0; srcSel    <= '0;   edgeSel   <= '0;
      reloadVal <= '0;
    end else begin
      if (wrLo) begin
        outEnable <= wrData[6];
        idleLevel <= wrData[5];
        reloadSel <= wrData[4];
        intEnable <= wrData[3];
        cntEnable <= wrData[1];
      end
      if (underflow)                  uFlag <= 1'b1;
      else if (wrLo && !wrData[2])    uFlag <= 1'b0;

      if (wrLo && !wrData[1])         running <= 1'b0;
      else if (startCmd)              running <= 1'b1;
      else if (underflow && !reloadSel) running <= 1'b0;

      if (wrEn && wrAddr == A_CTRL_HI) begin
        srcSel  <= wrData[5:3];
        edgeSel <= wrData[1:0];
      end
      if (wrEn && wrAddr == A_RLD_LO) reloadVal[7:0]       <= wrData;
      if (wrEn && wrAddr == A_RLD_HI) reloadVal[WIDTH-1:8] <= wrData[WIDTH-9:0];
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.loadStart = startCmd || (underflow && reloadSel);
    strobe.decrement = edgeHit && !(underflow && reloadSel);
    if (startCmd) begin
      strobe.pinSet    = 1'b1;
      strobe.pinSetVal = wrData[4] ? wrData[5] : ~wrData[5];
    end else if (underflow) begin
      strobe.pinSet    = !reloadSel;
      strobe.pinSetVal = idleLevel;
      strobe.pinToggle = reloadSel;
    end
  end

  assign ctrlLoRd = {1'b0, outEnable, idleLevel, reloadSel, intEnable, uFlag, cntEnable, 1'b0};
  assign ctrlHiRd = {2'b00, srcSel, 1'b0, edgeSel};
  assign irqOut   = uFlag && intEnable;

  // R6: an underflow always leaves the flag set
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> uFlag);
  // R13: clearing enable halts counting
  assert_enable_stop_R13: assert property (@(posedge clk) disable iff (!rstN)
    (wrLo && !wrData[1]) |=> !running);
  // R9: single-run stops on underflow
  assert_single_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !reloadSel && !startCmd) |=> !running);
  // R6: the flag only rises on an underflow
  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uFlag) |-> $past(underflow));
endmodule

// File: rtl/event_reload_timer.sv
module event_reload_timer
  import evt_timer_pkg::*;
#(
  parameter int WIDTH = CNT_W,
  parameter logic [2:0] SRC_CODE = EXT_SRC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  input  logic              evtIn,
  output logic              irqOut,
  output logic              pinOut
);
  ctrl_strobe_t     strobe;
  logic [WIDTH-1:0] reloadVal, countVal;
  logic [7:0]       ctrlLoRd, ctrlHiRd;
  logic             countZero, pinReg, outEnable, idleLevel;

  evt_timer_control #(.WIDTH(WIDTH), .SRC_CODE(SRC_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtIn(evtIn), .countZero(countZero), .strobe(strobe), .reloadVal(reloadVal),
    .ctrlLoRd(ctrlLoRd), .ctrlHiRd(ctrlHiRd), .irqOut(irqOut),
    .outEnable(outEnable), .idleLevel(idleLevel));

  evt_timer_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadVal),
    .countVal(countVal), .countZero(countZero), .pinReg(pinReg));

  assign pinOut = outEnable ? pinReg : idleLevel;

  always_comb begin
    case (rdAddr)
      A_CTRL_LO: rdData = ctrlLoRd;
      A_CTRL_HI: rdData = ctrlHiRd;
      A_RLD_LO:  rdData = reloadVal[7:0];
      A_RLD_HI:  rdData = reloadVal[WIDTH-1:8];
      A_CNT_LO:  rdData = countVal[7:0];
      A_CNT_HI:  rdData = countVal[WIDTH-1:8];
      default:   rdData = 8'h00;
    endcase
  end

  // R10: a disabled output shows the idle level
  assert_pin_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !outEnable |-> pinOut == idleLevel);
endmodule

// File: tb/event_reload_timer_bench.sv
module event_reload_timer_bench;
  logic       clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, evtIn = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0, rdData;
  logic       irqOut, pinOut;
  int errors = 0, checks = 0;
  bit watchdogHit = 1'b0;

  event_reload_timer u_event_reload_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtIn(evtIn), .irqOut(irqOut), .pinOut(pinOut));

  always #10 clk = ~clk;

  // {edge code(2), pad(2), pulses(4), start(16), expected(16)}
  localparam bit [39:0] VEC [7] = '{
    {2'b01, 2'b00, 4'd3, 16'h000A, 16'h0007},
    {2'b10, 2'b00, 4'd3, 16'h000A, 16'h0007},
    {2'b11, 2'b00, 4'd3, 16'h000A, 16'h0004},
    {2'b00, 2'b00, 4'd3, 16'h000A, 16'h000A},
    {2'b01, 2'b00, 4'd5, 16'h1205, 16'h1200},
    {2'b11, 2'b00, 4'd2, 16'h0100, 16'h00FC},
    {2'b01, 2'b00, 4'd1, 16'h0000, 16'hFFFF}
  };

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd16(logic [2:0] a, output logic [15:0] v);
    rdAddr = a;     #1 v[7:0]  = rdData;
    rdAddr = a + 1; #1 v[15:8] = rdData;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      evtIn = 1'b1; tick(4);
      evtIn = 1'b0; tick(4);
    end
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setStart(logic [15:0] v);
    wr(3'd2, v[7:0]); wr(3'd3, v[15:8]);
  endtask

  initial begin
    #3_000_000;
    watchdogHit = 1'b1;
  end

  initial begin
    logic [15:0] v;
    tick(2); rstN = 1'b1; tick(1);
    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rdAddr = 3'(a); #1 chk("R1 reg", {8'h00, rdData}, 16'h0000);
    end
    chk("R1 irq/pin", {14'd0, irqOut, pinOut}, 16'h0000);

    // Table walk: R3 edge codes, R5 decrement, R2 load
    foreach (VEC[k]) begin
      wr(3'd1, {2'b00, 3'b111, 1'b0, VEC[k][39:38]});
      setStart(VEC[k][31:16]);
      wr(3'd0, 8'h13);               // reload, enable, start
      rd16(3'd4, v); chk("R2 load", v, VEC[k][31:16]);
      pulse(int'(VEC[k][35:32]));
      rd16(3'd4, v);
      chk(k == 6 ? "R8 reload at zero" : "R3/R5 count", v,
          k == 6 ? 16'h0000 : VEC[k][15:0]);
    end
    rdAddr = 3'd0; #1 chk("R2 start reads 0", {15'd0, rdData[0]}, 16'h0000);

    // R4: source not external
    wr(3'd1, 8'h01); setStart(16'h0020); wr(3'd0, 8'h13);
    pulse(3); rd16(3'd4, v); chk("R4 source gate", v, 16'h0020);

    // Single-run: R9, R6, R7, R12
    wr(3'd1, 8'h39); setStart(16'h0002);
    wr(3'd0, 8'h4B);                 // outE, idle 0, inte, enable, start, flag clear
    tick(1); chk("R12 gate active", {15'd0, pinOut}, 16'h0001);
    pulse(2); rd16(3'd4, v); chk("R5 before zero", v, 16'h0000);
    chk("R7 irq low before", {15'd0, irqOut}, 16'h0000);
    pulse(1); rd16(3'd4, v); chk("R9 wrap", v, 16'hFFFF);
    chk("R7 irq", {15'd0, irqOut}, 16'h0001);
    chk("R12 gate idle", {15'd0, pinOut}, 16'h0000);
    rdAddr = 3'd0; #1 chk("R6 flag set", {15'd0, rdData[2]}, 16'h0001);
    pulse(2); rd16(3'd4, v); chk("R9 stopped", v, 16'hFFFF);
    wr(3'd0, 8'h4E);                 // write 1 to flag, no start
    rdAddr = 3'd0; #1 chk("R6 write1 keeps", {15'd0, rdData[2]}, 16'h0001);
    wr(3'd0, 8'h46);                 // inte off, flag kept
    chk("R7 irq masked", {15'd0, irqOut}, 16'h0000);
    wr(3'd0, 8'h42);                 // flag write 0
    rdAddr = 3'd0; #1 chk("R6 clear", {15'd0, rdData[2]}, 16'h0000);

    // Toggle mode: R8, R11
    setStart(16'h0001);
    wr(3'd0, 8'h73);                 // outE, idle 1, reload, enable, start
    tick(1); chk("R11 init", {15'd0, pinOut}, 16'h0001);
    pulse(2); rd16(3'd4, v); chk("R8 reloaded", v, 16'h0001);
    chk("R11 toggle1", {15'd0, pinOut}, 16'h0000);
    pulse(2); chk("R11 toggle2", {15'd0, pinOut}, 16'h0001);
    rdAddr = 3'd0; #1 chk("R6 set in reload", {15'd0, rdData[2]}, 16'h0001);

    // R10: output disabled
    wr(3'd0, 8'h36); chk("R10 idle hi", {15'd0, pinOut}, 16'h0001);
    wr(3'd0, 8'h16); chk("R10 idle lo", {15'd0, pinOut}, 16'h0000);

    // R13: enable cleared
    setStart(16'h0030); wr(3'd0, 8'h13); pulse(1);
    wr(3'd0, 8'h10); pulse(3);
    rd16(3'd4, v); chk("R13 halted", v, 16'h002F);

    if (watchdogHit) begin checks++; errors++; $display("FAIL watchdog"); end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge watchdogHit) begin
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule